// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers interrupt requests from eight lines, picks the most urgent one that software has not masked, and raises a single interrupt line toward a processor. When the processor answers with an acknowledge pulse, the block gives back an 8-bit vector in that same cycle and records the chosen input as in service. A request of higher priority can still interrupt while a lower one is in service. A request of the same or lower priority waits until an end-of-interrupt strobe retires the in-service entry.

Software configures the block through a small write port. It sets a vector base that is a multiple of 8, a mask bit for each input, one trigger mode shared by all eight inputs (edge or level), and an option to rotate priority. With rotation on, the input that was just retired drops to the lowest priority. If a request disappears between the interrupt and the acknowledge, the block still answers, using the vector of input 7. A handler can then read the request and in-service registers to tell a real input-7 event from a spurious one.

The acknowledge and vector exchange is a fixed one-cycle handshake with no back-pressure. The vector is only meaningful in a cycle where `int_ack` is high, and the processor must take it in that cycle. The request inputs are sampled into a register before use, so a change on a line shows at `int_out` one cycle later in level mode and two cycles later in edge mode.

Top module: `prio_intc`

## Requirements
- R1: In fixed-priority mode (rotation off), a lower input number wins arbitration: input 0 is the highest priority and input 7 the lowest.
- R2: A pending request raises `int_out` only if its priority is strictly above the highest-priority in-service input. Requests of equal or lower priority wait.
- R3: Rotation is enabled by writing bit 1 = 1 to register 2. While it is enabled, each end-of-interrupt that retires input k makes input (k+1) mod 8 the highest priority and input k the lowest. While rotation is off, the priority order never changes.
- R4: In edge mode (register 2 bit 0 = 0), a rising transition on a line latches a request that stays pending after the line falls. The latch is cleared when that input is acknowledged.
- R5: In level mode (register 2 bit 0 = 1), an input is pending exactly while its line is high.
- R6: `int_out` is high whenever an unmasked pending request passes the R2 rule, whether or not an acknowledge is in progress.
- R7: An acknowledge with no valid winner returns base + 7 and sets no in-service bit.
- R8: On an acknowledge with a winner, `vec_out` = base + input number. Writes to register 0 keep only bits 7:3 as the base, and a read of register 3 returns the base with bits 2:0 at zero.
- R9: A set bit in the mask register (write register 1) keeps that input out of arbitration, but its edge latch still records a request.
- R10: An `eoi` pulse clears only the highest-priority in-service bit. It has no effect when no bit is set.
- R11: After reset the state is: mask = 8'hFF, in-service = 0, base = 0, edge mode, rotation off, `int_out` low.
- R12: `rd_data` reads combinationally: rd_addr 0 gives the pending requests, 1 the in-service bits, 2 the mask, 3 the base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, bit i is input i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 base, 1 mask, 2 mode |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read select: 0 pending, 1 in-service, 2 mask, 3 base |
| rd_data | output | 8 | Read data, combinational |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge pulse |
| vec_out | output | 8 | Vector, valid in a cycle with int_ack high |
| eoi | input | 1 | One-cycle end-of-interrupt strobe |

## Verification
The hardest state to reach is a rotated priority order with nesting active: the pointer moves only when an end-of-interrupt retires a request while rotation is on. The stimulus first services input 4, which moves the top of the order to input 5. It then raises inputs 0 and 5 together, so the bench can see that input 5 wins and that input 0 stays blocked behind it. Further retirements walk the pointer around the wrap point, where input 7 outranks input 0. There the bench checks the in-service register to show that a genuine input-7 vector differs from a spurious one.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_IRQ = 8;
  localparam int IDX_W   = $clog2(NUM_IRQ);
  localparam int VEC_W   = 8;
  localparam int BASE_W  = VEC_W - IDX_W;

  typedef logic [NUM_IRQ-1:0] irq_vec_t;
  typedef logic [IDX_W-1:0]   irq_idx_t;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_MODE = 2'd2,
    SEL_AUX  = 2'd3
  } reg_sel_t;
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         level_mode,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] irq_s, irq_d, edge_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_s    <= '0;
      irq_d    <= '0;
      edge_lat <= '0;
    end else begin
      irq_s <= irq_in;
      irq_d <= irq_s;
      if (level_mode) edge_lat <= '0;
      else            edge_lat <= (edge_lat & ~ack_clr) | (irq_s & ~irq_d);
    end
  end

  assign pend = level_mode ? irq_s : edge_lat;
endmodule

// File: rtl/intc_resolve.sv
module intc_resolve #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] top,
  output logic         found,
  output logic [W-1:0] idx,
  output logic [W-1:0] rank
);
  // Scan from lowest priority to highest so the last hit is the winner.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int pos;
      pos = (int'(top) + k) % N;
      if (req[pos]) begin
        found = 1'b1;
        idx   = W'(pos);
        rank  = W'(k);
      end
    end
  end
endmodule

// File: rtl/intc_service.sv
module intc_service #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rot_en,
  input  logic         eoi,
  input  logic [N-1:0] ack_set,
  output logic [N-1:0] isr,
  output logic [W-1:0] top,
  output logic         isr_found,
  output logic [W-1:0] isr_rank
);
  logic [W-1:0] isr_idx;
  logic [N-1:0] eoi_clr;
  logic         retire;

  intc_resolve #(.N(N), .W(W)) u_isr_pick (
    .req   (isr),
    .top   (top),
    .found (isr_found),
    .idx   (isr_idx),
    .rank  (isr_rank)
  );

  assign retire = eoi && isr_found;

  always_comb begin
    eoi_clr = '0;
    if (retire) eoi_clr[isr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr <= '0;
      top <= '0;
    end else begin
      isr <= (isr & ~eoi_clr) | ack_set;
      if (retire && rot_en) top <= W'((int'(isr_idx) + 1) % N);
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [1:0]         rd_addr,
  output logic [7:0]         rd_data,
  output logic               int_out,
  input  logic               int_ack,
  output logic [VEC_W-1:0]   vec_out,
  input  logic               eoi
);
  logic [BASE_W-1:0] base_hi;
  irq_vec_t          mask, pend, cand, isr, take;
  logic              level_mode, rot_en;
  irq_idx_t          top, win_idx, win_rank, isr_rank, sel;
  logic              win_found, isr_found, win_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi    <= '0;
      mask       <= '1;
      level_mode <= 1'b0;
      rot_en     <= 1'b0;
    end else if (wr_en) begin
      unique case (reg_sel_t'(wr_addr))
        SEL_BASE: base_hi <= wr_data[VEC_W-1:IDX_W];
        SEL_MASK: mask    <= wr_data[NUM_IRQ-1:0];
        SEL_MODE: begin
          level_mode <= wr_data[0];
          rot_en     <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  intc_capture #(.N(NUM_IRQ)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .level_mode (level_mode),
    .ack_clr    (take),
    .pend       (pend)
  );

  assign cand = pend & ~mask;

  intc_resolve #(.N(NUM_IRQ), .W(IDX_W)) u_req_pick (
    .req   (cand),
    .top   (top),
    .found (win_found),
    .idx   (win_idx),
    .rank  (win_rank)
  );

  intc_service #(.N(NUM_IRQ), .W(IDX_W)) u_service (
    .clk       (clk),
    .rst_n     (rst_n),
    .rot_en    (rot_en),
    .eoi       (eoi),
    .ack_set   (take),
    .isr       (isr),
    .top       (top),
    .isr_found (isr_found),
    .isr_rank  (isr_rank)
  );

  assign win_ok  = win_found && (!isr_found || (win_rank < isr_rank));
  assign int_out = win_ok;
  assign sel     = win_ok ? win_idx : irq_idx_t'(NUM_IRQ - 1);
  assign vec_out = {base_hi, sel};

  always_comb begin
    take = '0;
    if (int_ack && win_ok) take[win_idx] = 1'b1;
  end

  always_comb begin
    unique case (rd_addr)
      2'd0:    rd_data = 8'(pend);
      2'd1:    rd_data = 8'(isr);
      2'd2:    rd_data = 8'(mask);
      default: rd_data = {base_hi, {IDX_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int N = 8,
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         int_ack,
  input logic         int_out,
  input logic         eoi,
  input logic         rot_en,
  input logic [N-1:0] isr,
  input logic [N-1:0] pend,
  input logic [N-1:0] mask,
  input logic [W-1:0] top,
  input logic [7:0]   vec_out
);
  assert_spurious_no_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_out && !eoi) |=> (isr == $past(isr)));

  assert_spurious_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_out) |-> (vec_out[W-1:0] == W'(N - 1)));

  assert_ack_sets_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out && !eoi) |=> ($countones(isr) == $countones($past(isr)) + 1));

  assert_eoi_clears_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !int_ack && (isr != '0)) |=> ($countones(isr) + 1 == $countones($past(isr))));

  assert_eoi_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !int_ack && (isr == '0)) |=> (isr == '0));

  assert_no_rotation_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_en |=> $stable(top));

  assert_unmasked_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((pend & ~mask) != '0));
endmodule

bind prio_intc intc_checker #(.N(intc_pkg::NUM_IRQ), .W(intc_pkg::IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .int_ack (int_ack),
  .int_out (int_out),
  .eoi     (eoi),
  .rot_en  (rot_en),
  .isr     (isr),
  .pend    (pend),
  .mask    (mask),
  .top     (top),
  .vec_out (vec_out)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       int_out;
  logic       int_ack = 1'b0;
  logic [7:0] vec_out;
  logic       eoi = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .int_out(int_out), .int_ack(int_ack),
    .vec_out(vec_out), .eoi(eoi)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected vector for every acknowledge cycle.
  always @(negedge clk) begin
    if (int_ack) begin
      if (exp_q.size() == 0) check(1'b0, "unexpected ack", vec_out, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(vec_out == e, t, vec_out, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string tag);
    rd_addr = a;
    #1;
    check(rd_data == e, tag, rd_data, e);
  endtask

  task automatic out_chk(input logic e, input string tag);
    check(int_out == e, tag, int_out, e);
  endtask

  task automatic pulse(input logic [7:0] lines);
    irq_in = irq_in | lines;
    step(1);
    irq_in = irq_in & ~lines;
    step(3);
  endtask

  task automatic ack(input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    int_ack = 1'b1;
    step(1);
    int_ack = 1'b0;
    #1;
  endtask

  task automatic end_irq();
    eoi = 1'b1;
    step(1);
    eoi = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11 reset state
    out_chk(1'b0, "R11 int_out after reset");
    rd_chk(2'd2, 8'hFF, "R11 mask after reset");
    rd_chk(2'd1, 8'h00, "R11 isr after reset");
    rd_chk(2'd3, 8'h00, "R11 base after reset");

    // R8 base alignment, R12 readback
    wr(2'd0, 8'h27);
    rd_chk(2'd3, 8'h20, "R8 base low bits dropped");
    wr(2'd1, 8'h00);
    rd_chk(2'd2, 8'h00, "R12 mask readback");

    // R4 edge latch, R6 output, R8 vector
    pulse(8'h08);
    out_chk(1'b1, "R6 int_out after edge on 3");
    rd_chk(2'd0, 8'h08, "R4 edge latched after line fell");
    ack(8'h23, "R8 vector for input 3");
    rd_chk(2'd1, 8'h08, "R4 isr bit 3 set");
    rd_chk(2'd0, 8'h00, "R4 latch cleared by ack");
    pulse(8'h08);
    out_chk(1'b0, "R2 equal priority waits");

    // R2 nesting
    pulse(8'h20);
    out_chk(1'b0, "R2 lower priority 5 waits");
    pulse(8'h02);
    out_chk(1'b1, "R2 higher priority 1 nests");
    ack(8'h21, "R2 nested vector for input 1");
    rd_chk(2'd1, 8'h0A, "R2 isr holds 1 and 3");
    end_irq();
    rd_chk(2'd1, 8'h08, "R10 eoi clears highest only");
    out_chk(1'b0, "R2 still blocked by 3");
    end_irq();
    out_chk(1'b1, "R2 pending resumes");
    ack(8'h23, "R1 input 3 before 5");
    end_irq();
    ack(8'h25, "R1 then input 5");
    end_irq();
    rd_chk(2'd1, 8'h00, "R10 isr empty");
    end_irq();
    rd_chk(2'd1, 8'h00, "R10 eoi with empty isr");

    // R9 mask
    wr(2'd1, 8'h04);
    pulse(8'h04);
    out_chk(1'b0, "R9 masked input silent");
    rd_chk(2'd0, 8'h04, "R9 latch records masked edge");
    wr(2'd1, 8'h00);
    out_chk(1'b1, "R9 unmask releases request");
    ack(8'h22, "R9 vector after unmask");
    end_irq();

    // R1 fixed order with simultaneous requests
    pulse(8'h44);
    ack(8'h22, "R1 input 2 beats 6");
    end_irq();
    ack(8'h26, "R1 input 6 afterwards");
    end_irq();

    // R7 spurious, R5 level mode
    wr(2'd2, 8'h01);
    out_chk(1'b0, "R7 nothing pending");
    ack(8'h27, "R7 spurious vector");
    rd_chk(2'd1, 8'h00, "R7 no isr after spurious");
    irq_in = 8'h40;
    step(2);
    out_chk(1'b1, "R5 level high requests");
    rd_chk(2'd0, 8'h40, "R5 pending follows line");
    ack(8'h26, "R5 level vector input 6");
    rd_chk(2'd1, 8'h40, "R5 isr bit 6");
    out_chk(1'b0, "R2 level same input waits");
    end_irq();
    out_chk(1'b1, "R5 line still high re-requests");
    irq_in = 8'h00;
    step(2);
    out_chk(1'b0, "R5 line low drops request");
    rd_chk(2'd0, 8'h00, "R5 pending cleared with line");

    // R3 rotation (edge mode)
    wr(2'd2, 8'h02);
    pulse(8'h10);
    ack(8'h24, "R3 input 4 serviced");
    end_irq();
    pulse(8'h21);
    ack(8'h25, "R3 input 5 now highest");
    out_chk(1'b0, "R3 input 0 ranks below 5");
    end_irq();
    ack(8'h20, "R3 input 0 after 5 retired");
    end_irq();
    pulse(8'h81);
    ack(8'h27, "R3 input 7 outranks 0");
    rd_chk(2'd1, 8'h80, "R3 genuine 7 sets isr");
    end_irq();
    ack(8'h20, "R3 input 0 last");
    end_irq();
    rd_chk(2'd1, 8'h00, "R3 isr empty at end");

    step(2);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule